// File: doc/BRIEF.md
# Two-Port Source Select Controller

This block is the digital control plane of a sink-side switch that feeds one video receiver from two source connectors. It decides which connector is active, which connector presents its line terminations, which connector's display-data-channel clock and data lines reach the sink, and what each source sees on its hot-plug line.

Selection comes from one of two places. A mode pin picks between a pair of select pins and a 2-bit selection field held in a control register. A power pin overrides both. When it is low, the block parks every output in a quiet, high-impedance state.

Every pin input passes through a two-flop synchronizer, and every output is registered. The termination enables are always decoded together, so a port change is a single-cycle handover.

Top module: `srcsel_ctrl`

## Requirements
- R1: Pin control (`bus_ctl_pin`=0, `pwr_on_pin`=1) with `sel_hi_pin`=1, `sel_lo_pin`=1 makes port 1 active. The outputs are `act_port`=1 and `term_en`=2'b01 (bit 0 is port 1). `hpd_out[0]` follows `sink_hpd` and `hpd_out[1]` is 0.
- R2: Pin control with `sel_hi_pin`=1, `sel_lo_pin`=0 makes port 2 active. The outputs are `act_port`=2 and `term_en`=2'b10. `hpd_out[1]` follows `sink_hpd` and `hpd_out[0]` is 0.
- R3: Pin control with `sel_hi_pin`=0 is standby. The outputs are `act_port`=0 and `term_en`=2'b00, and both `hpd_out` bits follow `sink_hpd`.
- R4: Register control (`bus_ctl_pin`=1) decodes `reg_sel` as follows:
  - 2'b11 selects port 1, as in R1.
  - 2'b10 selects port 2, as in R2.
  - 2'b01 is standby, as in R3.
  - 2'b00 is a blocked state with `act_port`=0, `term_en`=2'b00 and `hpd_out`=2'b00.
- R5: Only the control source chosen by `bus_ctl_pin` has any effect. `reg_sel` is ignored under pin control, and the select pins are ignored under register control.
- R6: While `pwr_on_pin` is low, the outputs are `hiz_en`=1, `act_port`=0, `term_en`=0, `hpd_out`=0, and both sink-side lines are 1, whatever the other inputs do.
- R7: `ddc_scl_sink` and `ddc_sda_sink` carry the active port's `src_scl` and `src_sda` bits. When no port is active they idle at 1.
- R8: A change on any pin appears at the outputs after exactly three clock edges. A change on `reg_sel`, `sink_hpd`, `src_scl` or `src_sda` appears after exactly one clock edge.
- R9: At most one `term_en` bit is set in any cycle. A direct switch from port 1 to port 2 takes `term_en` from 2'b01 to 2'b10 across a single edge.
- R10: While `rst` is high, the outputs hold the low-power state of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_hi_pin | input | 1 | Upper select pin, asynchronous |
| sel_lo_pin | input | 1 | Lower select pin, asynchronous |
| pwr_on_pin | input | 1 | 1 = normal operation, 0 = low power, asynchronous |
| bus_ctl_pin | input | 1 | 0 = select pins control, 1 = register field controls, asynchronous |
| reg_sel | input | 2 | Selection field from the control register |
| sink_hpd | input | 1 | Hot-plug level from the sink |
| src_scl | input | 2 | Data-channel clock from each source, bit 0 = port 1 |
| src_sda | input | 2 | Data-channel data from each source, bit 0 = port 1 |
| act_port | output | 2 | Active port code: 0 none, 1 port 1, 2 port 2 |
| term_en | output | 2 | Termination enable per port |
| hpd_out | output | 2 | Hot-plug level toward each source |
| hiz_en | output | 1 | High-impedance enable for all port outputs |
| ddc_scl_sink | output | 1 | Data-channel clock toward the sink |
| ddc_sda_sink | output | 1 | Data-channel data toward the sink |

## Verification
Pin-driven results are due three edges after the stimulus, and register, hot-plug and data-channel results one edge after. The random phase drives new inputs on a falling edge and holds them for four edges before comparing, which covers the longer path.

The directed latency checks count falling edges after a change and sample at the exact edge. One sample is taken one edge early, where the old value must still be present, and one at the due edge, where the new value must appear. The port-to-port handover is observed on those same two samples, which shows the termination pair moving between ports with no cycle in between.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;
  typedef enum logic [2:0] {
    MD_OFF,
    MD_P1,
    MD_P2,
    MD_STBY,
    MD_BLOCK
  } mode_e;

  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_P1   = 2'd1;
  localparam logic [1:0] ACT_P2   = 2'd2;

  localparam logic [1:0] RSEL_P1    = 2'b11;
  localparam logic [1:0] RSEL_P2    = 2'b10;
  localparam logic [1:0] RSEL_STBY  = 2'b01;
  localparam logic [1:0] RSEL_BLOCK = 2'b00;
endpackage

// File: rtl/srcsel_sync.sv
module srcsel_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srcsel_decode.sv
module srcsel_decode
  import srcsel_pkg::*;
(
  input  logic       pwr_ok,
  input  logic       bus_ctl,
  input  logic       pin_hi,
  input  logic       pin_lo,
  input  logic [1:0] reg_sel,
  output mode_e      mode
);
  always_comb begin
    if (!pwr_ok) begin
      mode = MD_OFF;
    end else if (bus_ctl) begin
      unique case (reg_sel)
        RSEL_P1:   mode = MD_P1;
        RSEL_P2:   mode = MD_P2;
        RSEL_STBY: mode = MD_STBY;
        default:   mode = MD_BLOCK;
      endcase
    end else if (!pin_hi) begin
      mode = MD_STBY;
    end else begin
      mode = pin_lo ? MD_P1 : MD_P2;
    end
  end
endmodule

// File: rtl/srcsel_outreg.sv
module srcsel_outreg
  import srcsel_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic             sink_hpd,
  input  logic [NPORT-1:0] src_scl,
  input  logic [NPORT-1:0] src_sda,
  output logic [1:0]       act_port,
  output logic [NPORT-1:0] term_en,
  output logic [NPORT-1:0] hpd_out,
  output logic             hiz_en,
  output logic             ddc_scl_sink,
  output logic             ddc_sda_sink
);
  logic [NPORT-1:0] is_port;
  logic             stby;

  assign is_port[0] = (mode == MD_P1);
  assign is_port[1] = (mode == MD_P2);
  assign stby       = (mode == MD_STBY);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        term_en[p] <= 1'b0;
        hpd_out[p] <= 1'b0;
      end else begin
        term_en[p] <= is_port[p];
        hpd_out[p] <= (is_port[p] | stby) & sink_hpd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_port     <= ACT_NONE;
      hiz_en       <= 1'b1;
      ddc_scl_sink <= 1'b1;
      ddc_sda_sink <= 1'b1;
    end else begin
      hiz_en <= (mode == MD_OFF);
      unique case (1'b1)
        is_port[0]: begin
          act_port     <= ACT_P1;
          ddc_scl_sink <= src_scl[0];
          ddc_sda_sink <= src_sda[0];
        end
        is_port[1]: begin
          act_port     <= ACT_P2;
          ddc_scl_sink <= src_scl[1];
          ddc_sda_sink <= src_sda[1];
        end
        default: begin
          act_port     <= ACT_NONE;
          ddc_scl_sink <= 1'b1;
          ddc_sda_sink <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/srcsel_ctrl.sv
module srcsel_ctrl
  import srcsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_hi_pin,
  input  logic       sel_lo_pin,
  input  logic       pwr_on_pin,
  input  logic       bus_ctl_pin,
  input  logic [1:0] reg_sel,
  input  logic       sink_hpd,
  input  logic [1:0] src_scl,
  input  logic [1:0] src_sda,
  output logic [1:0] act_port,
  output logic [1:0] term_en,
  output logic [1:0] hpd_out,
  output logic       hiz_en,
  output logic       ddc_scl_sink,
  output logic       ddc_sda_sink
);
  localparam int NPIN  = 4;
  localparam int NPORT = 2;

  logic [NPIN-1:0] pin_raw, pin_s;
  mode_e           mode;

  assign pin_raw = {bus_ctl_pin, pwr_on_pin, sel_hi_pin, sel_lo_pin};

  srcsel_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_s)
  );

  srcsel_decode u_dec (
    .pwr_ok  (pin_s[2]),
    .bus_ctl (pin_s[3]),
    .pin_hi  (pin_s[1]),
    .pin_lo  (pin_s[0]),
    .reg_sel (reg_sel),
    .mode    (mode)
  );

  srcsel_outreg #(.NPORT(NPORT)) u_out (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .sink_hpd     (sink_hpd),
    .src_scl      (src_scl),
    .src_sda      (src_sda),
    .act_port     (act_port),
    .term_en      (term_en),
    .hpd_out      (hpd_out),
    .hiz_en       (hiz_en),
    .ddc_scl_sink (ddc_scl_sink),
    .ddc_sda_sink (ddc_sda_sink)
  );
endmodule

// File: rtl/srcsel_chk.sv
module srcsel_chk (
  input logic       clk,
  input logic       rst,
  input logic       sink_hpd,
  input logic [1:0] src_scl,
  input logic [1:0] src_sda,
  input logic [1:0] act_port,
  input logic [1:0] term_en,
  input logic [1:0] hpd_out,
  input logic       hiz_en,
  input logic       ddc_scl_sink,
  input logic       ddc_sda_sink
);
  AST_TERM_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(term_en)); // R9
  AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (rst)
    hiz_en |-> (act_port == 2'd0 && term_en == 2'b00 && hpd_out == 2'b00 && ddc_scl_sink && ddc_sda_sink)); // R6
  AST_P1_TERM: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd1 |-> (term_en == 2'b01 && !hpd_out[1])); // R1
  AST_P1_HPD: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd1 |-> hpd_out[0] == $past(sink_hpd)); // R1
  AST_P2_TERM: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd2 |-> (term_en == 2'b10 && !hpd_out[0] && hpd_out[1] == $past(sink_hpd))); // R2
  AST_IDLE_NO_TERM: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd0 |-> term_en == 2'b00); // R3
  AST_DDC_ROUTE_P1: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd1 |-> (ddc_scl_sink == $past(src_scl[0]) && ddc_sda_sink == $past(src_sda[0]))); // R7
  AST_DDC_ROUTE_P2: assert property (@(posedge clk) disable iff (rst)
    act_port == 2'd2 |-> (ddc_scl_sink == $past(src_scl[1]) && ddc_sda_sink == $past(src_sda[1]))); // R7
endmodule

bind srcsel_ctrl srcsel_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sink_hpd     (sink_hpd),
  .src_scl      (src_scl),
  .src_sda      (src_sda),
  .act_port     (act_port),
  .term_en      (term_en),
  .hpd_out      (hpd_out),
  .hiz_en       (hiz_en),
  .ddc_scl_sink (ddc_scl_sink),
  .ddc_sda_sink (ddc_sda_sink)
);

// File: tb/srcsel_ctrl_tb.sv
module srcsel_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_hi_pin = 1'b0, sel_lo_pin = 1'b0, pwr_on_pin = 1'b0, bus_ctl_pin = 1'b0;
  logic [1:0] reg_sel = 2'b00;
  logic       sink_hpd = 1'b0;
  logic [1:0] src_scl = 2'b11, src_sda = 2'b11;
  logic [1:0] act_port, term_en, hpd_out;
  logic       hiz_en, ddc_scl_sink, ddc_sda_sink;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  srcsel_ctrl u_dut (
    .clk(clk), .rst(rst),
    .sel_hi_pin(sel_hi_pin), .sel_lo_pin(sel_lo_pin),
    .pwr_on_pin(pwr_on_pin), .bus_ctl_pin(bus_ctl_pin),
    .reg_sel(reg_sel), .sink_hpd(sink_hpd),
    .src_scl(src_scl), .src_sda(src_sda),
    .act_port(act_port), .term_en(term_en), .hpd_out(hpd_out),
    .hiz_en(hiz_en), .ddc_scl_sink(ddc_scl_sink), .ddc_sda_sink(ddc_sda_sink)
  );

  // packed expectation: {act[1:0], term[1:0], hpd[1:0], hiz, scl, sda}
  function automatic logic [8:0] model();
    logic [1:0] act;
    logic [1:0] trm;
    logic [1:0] hpd;
    logic       hiz;
    logic       stby;
    logic       blk;
    act = 2'd0; trm = 2'b00; hpd = 2'b00; hiz = 1'b0; stby = 1'b0; blk = 1'b0;
    if (!pwr_on_pin) hiz = 1'b1;
    else if (bus_ctl_pin) begin
      if (reg_sel == 2'b11) act = 2'd1;
      else if (reg_sel == 2'b10) act = 2'd2;
      else if (reg_sel == 2'b01) stby = 1'b1;
      else blk = 1'b1;
    end else if (!sel_hi_pin) stby = 1'b1;
    else act = sel_lo_pin ? 2'd1 : 2'd2;
    if (act == 2'd1) begin trm = 2'b01; hpd = {1'b0, sink_hpd}; end
    if (act == 2'd2) begin trm = 2'b10; hpd = {sink_hpd, 1'b0}; end
    if (stby) hpd = {sink_hpd, sink_hpd};
    if (blk) hpd = 2'b00;
    return {act, trm, hpd, hiz,
            (act == 2'd1) ? src_scl[0] : (act == 2'd2) ? src_scl[1] : 1'b1,
            (act == 2'd1) ? src_sda[0] : (act == 2'd2) ? src_sda[1] : 1'b1};
  endfunction

  function automatic logic [8:0] observed();
    return {act_port, term_en, hpd_out, hiz_en, ddc_scl_sink, ddc_sda_sink};
  endfunction

  task automatic check(input string req, input logic [8:0] exp_v);
    checks++;
    if (observed() !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, observed(), exp_v);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] before_v;
    void'($urandom(32'h5e1ec7));
    repeat (3) @(negedge clk);
    check("R10 reset", 9'b00_00_00_1_1_1);
    pwr_on_pin = 1'b1; sel_hi_pin = 1'b1; sel_lo_pin = 1'b1; sink_hpd = 1'b1;
    @(negedge clk);
    check("R10 reset held", 9'b00_00_00_1_1_1);
    rst = 1'b0;

    // R1 port 1 via pins
    settle(); src_scl = 2'b10; src_sda = 2'b01; @(negedge clk);
    check("R1 pin port1", 9'b01_01_01_0_0_1);
    check("R7 route port1", model());
    // R2/R8/R9 latency and handover
    sel_lo_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pin latency old", 9'b01_01_01_0_0_1);
    @(negedge clk);
    check("R9 handover port2", 9'b10_10_10_0_1_0);
    check("R2 pin port2", model());
    // R3 standby
    sel_hi_pin = 1'b0; settle();
    check("R3 standby", 9'b00_00_11_0_1_1);
    sink_hpd = 1'b0; @(negedge clk);
    check("R8 hpd latency", 9'b00_00_00_0_1_1);
    // R5 reg ignored under pin control
    sel_hi_pin = 1'b1; sel_lo_pin = 1'b1; sink_hpd = 1'b1; settle();
    reg_sel = 2'b10; settle();
    check("R5 reg ignored", 9'b01_01_01_0_0_1);
    // R4 register control
    bus_ctl_pin = 1'b1; settle();
    check("R4 reg port2", 9'b10_10_10_0_1_0);
    reg_sel = 2'b11; @(negedge clk);
    check("R8 reg latency", 9'b01_01_01_0_0_1);
    reg_sel = 2'b01; @(negedge clk);
    check("R4 reg standby", 9'b00_00_11_0_1_1);
    reg_sel = 2'b00; @(negedge clk);
    check("R4 reg blocked", 9'b00_00_00_0_1_1);
    reg_sel = 2'b10; @(negedge clk);
    before_v = observed();
    sel_lo_pin = 1'b0; sel_hi_pin = 1'b0; settle();
    check("R5 pins ignored", before_v);
    // R6 low power
    pwr_on_pin = 1'b0; settle();
    check("R6 low power", 9'b00_00_00_1_1_1);
    bus_ctl_pin = 1'b0; sel_hi_pin = 1'b1; reg_sel = 2'b11; settle();
    check("R6 others ignored", 9'b00_00_00_1_1_1);

    // random phase
    for (int i = 0; i < 400; i++) begin
      sel_hi_pin  = 1'($urandom);
      sel_lo_pin  = 1'($urandom);
      pwr_on_pin  = ($urandom % 8) != 0;
      bus_ctl_pin = 1'($urandom);
      reg_sel     = 2'($urandom);
      sink_hpd    = 1'($urandom);
      src_scl     = 2'($urandom);
      src_sda     = 2'($urandom);
      settle();
      check("R1 R2 R3 R4 R5 R6 R7 random", model());
      src_scl = 2'($urandom); src_sda = 2'($urandom);
      @(negedge clk);
      check("R7 R8 random route", model());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule